// File: doc/BRIEF.md
# Stop-Mode Wake-Up Source Selector

This block decides when a microcontroller should leave its low-power stop state by watching the levels of its general-purpose port pins. Software programs a write-only wake configuration register. A 3-bit source field in that register picks one NAND or NOR over a fixed group of pins. A level bit picks whether a low or a high result of that function starts recovery.

A second path compares port 3 pins 0 to 3 against a stored reference nibble. Any mismatch on an enabled pin counts as a wake event. The reference nibble can be written by software or captured from the pins. Pins that software marks in a per-pin wake-select vector, and pins that drive as outputs, are left out of the NAND/NOR function.

Every pin passes through a two-flop synchronizer. The block ORs the enabled sources together and gates the result with the stop-mode input. It then emits a registered one-cycle pulse on the rising edge of that combined condition. All pins are plain control and status signals; there is no streaming interface, so no valid/ready handshake applies.

Top module: `stop_wake_sel`

## Requirements
- R1: After reset the wake request is 0, the source field is 000 and the level bit is 0. In this state no wake occurs, even when stop mode is asserted and all pins are low.
- R2: The source field is cfg_wdata[4:2], and each code selects one group and one function:
  - 000: no source.
  - 001: NAND of p2[3:0].
  - 010: NAND of p2[7:0].
  - 011: NOR of p3[3:1].
  - 100: NAND of p3[3:1].
  - 101: NOR of p3[3:1], p0[0] and p0[7].
  - 110: NAND of p3[3:1], p0[0] and p0[7].
  - 111: NAND of p3[3:1] and p2[2:0].
- R3: The level bit is cfg_wdata[6]. With 0 the group source fires when the function result is 0. With 1 it fires when the result is 1.
- R4: Bits 7, 5, 1 and 0 of cfg_wdata are reserved. Their values have no effect on wake behaviour.
- R5: A pin whose output-enable bit or wake-select bit is 1 is left out of the group function. If every pin of the selected group is excluded, the group never fires.
- R6: ref_wdata[3:0] enables the compare for p3 pins 0 to 3, and ref_wdata[7:4] is the reference nibble for those pins. Any enabled pin whose synchronized level differs from its reference bit is a wake event.
- R7: A one-cycle ref_sample, when ref_we is low, loads the synchronized p3[3:0] into the reference nibble.
- R8: The reference register changes only on ref_we or ref_sample. It keeps its value across wake events.
- R9: The group source and the reference mismatch are ORed. Either one alone causes a wake.
- R10: Wake detection is armed only while stop_mode is 1. With stop_mode at 0, wake_req stays 0 whatever the pins do.
- R11: wake_req is a one-cycle pulse on the rising edge of the armed condition.
  - A pin change reaches wake_req after three clock edges.
  - A rise of stop_mode with the condition already true reaches wake_req after one edge.
- R12: The configuration register changes only on a cycle with cfg_we high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| stop_mode | input | 1 | High while the core is in stop state; arms detection |
| cfg_we | input | 1 | Write strobe for the wake configuration register |
| cfg_wdata | input | 8 | Configuration data: [6] level, [4:2] source |
| ref_we | input | 1 | Write strobe for the reference-compare register |
| ref_wdata | input | 8 | [7:4] reference nibble, [3:0] per-pin compare enable |
| ref_sample | input | 1 | Capture synchronized p3[3:0] as reference nibble |
| p0_in | input | 8 | Port 0 pin levels (asynchronous) |
| p2_in | input | 8 | Port 2 pin levels (asynchronous) |
| p3_in | input | 8 | Port 3 pin levels (asynchronous) |
| p0_oe | input | 8 | Port 0 output-enable per pin |
| p2_oe | input | 8 | Port 2 output-enable per pin |
| p3_oe | input | 8 | Port 3 output-enable per pin |
| p0_wsel | input | 8 | Port 0 per-pin wake-select (excludes pin from group) |
| p2_wsel | input | 8 | Port 2 per-pin wake-select (excludes pin from group) |
| p3_wsel | input | 8 | Port 3 per-pin wake-select (excludes pin from group) |
| wake_req | output | 1 | One-cycle wake request pulse |

## Verification
The bench sweeps every source code at both levels. It drives all-low, all-high, fully excluded and pseudo-random pin and exclusion patterns, so a wrong group membership, swapped NAND and NOR, or an inverted level bit shows up as a missing or spurious pulse. It walks all 256 combinations of reference nibble and pin nibble with every compare enabled; a comparator that looked at the wrong bit or the wrong polarity would miss mismatches. Further tests cover the following cases:
- Reserved configuration bits set to random values.
- Pin activity in run mode.
- The exact three-edge pin-to-pulse latency.
- Loss of the reference after a wake.
- A failed sample capture.

A design that leaked any of these would pulse when it should not, or pulse late.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
  localparam int PORT_W = 8;
  localparam int NPINS  = 3 * PORT_W;

  typedef enum logic [2:0] {
    SRC_NONE      = 3'd0,
    SRC_P2LO_NAND = 3'd1,
    SRC_P2_NAND   = 3'd2,
    SRC_P3_NOR    = 3'd3,
    SRC_P3_NAND   = 3'd4,
    SRC_P3P0_NOR  = 3'd5,
    SRC_P3P0_NAND = 3'd6,
    SRC_P3P2_NAND = 3'd7
  } src_e;

  typedef struct packed {
    logic level;
    src_e src;
  } cfg_t;

  // Pin vector layout: [7:0] port 0, [15:8] port 2, [23:16] port 3
  function automatic logic [NPINS-1:0] group_members(src_e s);
    logic [NPINS-1:0] m;
    m = '0;
    case (s)
      SRC_P2LO_NAND: m[PORT_W+3:PORT_W] = 4'hF;
      SRC_P2_NAND:   m[2*PORT_W-1:PORT_W] = '1;
      SRC_P3_NOR, SRC_P3_NAND: m[2*PORT_W+3:2*PORT_W+1] = 3'b111;
      SRC_P3P0_NOR, SRC_P3P0_NAND: begin
        m[2*PORT_W+3:2*PORT_W+1] = 3'b111;
        m[0] = 1'b1;
        m[7] = 1'b1;
      end
      SRC_P3P2_NAND: begin
        m[2*PORT_W+3:2*PORT_W+1] = 3'b111;
        m[PORT_W+2:PORT_W] = 3'b111;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic is_nor(src_e s);
    return (s == SRC_P3_NOR) || (s == SRC_P3P0_NOR);
  endfunction
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

  generate
    if (STAGES > 1) begin : g_chk
      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        q == $past(stg[STAGES-2])); // R11
    end
  endgenerate
endmodule

// File: rtl/wake_group_fn.sv
module wake_group_fn
  import stop_wake_pkg::*;
(
  input  cfg_t             cfg,
  input  logic [NPINS-1:0] pins,
  input  logic [NPINS-1:0] excl,
  output logic             hit,
  output logic             any_incl
);
  logic [NPINS-1:0] incl;
  logic nand_res, nor_res, res;

  always_comb begin
    incl     = group_members(cfg.src) & ~excl;
    // excluded pins forced to 1 for NAND, 0 for NOR
    nand_res = ~&(pins | ~incl);
    nor_res  = ~|(pins & incl);
    res      = is_nor(cfg.src) ? nor_res : nand_res;
    any_incl = |incl;
    hit      = (cfg.src != SRC_NONE) && any_incl && (res == cfg.level);
  end
endmodule

// File: rtl/wake_ref_cmp.sv
module wake_ref_cmp #(
  parameter int REF_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_we,
  input  logic [2*REF_W-1:0] ref_wdata,
  input  logic             ref_sample,
  input  logic [REF_W-1:0] pins,
  output logic             mismatch
);
  logic [REF_W-1:0] en_q, ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ref_q <= '0;
    end else if (ref_we) begin
      en_q  <= ref_wdata[REF_W-1:0];
      ref_q <= ref_wdata[2*REF_W-1:REF_W];
    end else if (ref_sample) begin
      ref_q <= pins;
    end
  end

  assign mismatch = |(en_q & (pins ^ ref_q));

  AST_REF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_we && !ref_sample) |=> $stable({en_q, ref_q})); // R8
  AST_REF_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sample && !ref_we) |=> (ref_q == $past(pins))); // R7
endmodule

// File: rtl/stop_wake_sel.sv
module stop_wake_sel
  import stop_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REF_W       = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stop_mode,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  input  logic        ref_we,
  input  logic [7:0]  ref_wdata,
  input  logic        ref_sample,
  input  logic [7:0]  p0_in,
  input  logic [7:0]  p2_in,
  input  logic [7:0]  p3_in,
  input  logic [7:0]  p0_oe,
  input  logic [7:0]  p2_oe,
  input  logic [7:0]  p3_oe,
  input  logic [7:0]  p0_wsel,
  input  logic [7:0]  p2_wsel,
  input  logic [7:0]  p3_wsel,
  output logic        wake_req
);
  localparam int LEVEL_BIT = 6;
  localparam int SRC_LSB   = 2;

  cfg_t             cfg_q;
  logic [NPINS-1:0] pins_raw, pins_s, excl;
  logic             grp_hit, grp_any, ref_mis;
  logic             cond, cond_q;

  // configuration register: reserved bits dropped on write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{level: 1'b0, src: SRC_NONE};
    end else if (cfg_we) begin
      cfg_q.level <= cfg_wdata[LEVEL_BIT];
      cfg_q.src   <= src_e'(cfg_wdata[SRC_LSB+2:SRC_LSB]);
    end
  end

  assign pins_raw = {p3_in, p2_in, p0_in};
  assign excl     = {p3_oe | p3_wsel, p2_oe | p2_wsel, p0_oe | p0_wsel};

  wake_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
  );

  wake_group_fn u_grp (
    .cfg(cfg_q), .pins(pins_s), .excl(excl), .hit(grp_hit), .any_incl(grp_any)
  );

  wake_ref_cmp #(.REF_W(REF_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_we(ref_we), .ref_wdata(ref_wdata),
    .ref_sample(ref_sample), .pins(pins_s[2*PORT_W+REF_W-1:2*PORT_W]),
    .mismatch(ref_mis)
  );

  assign cond = stop_mode && (grp_hit || ref_mis);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cond_q   <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      cond_q   <= cond;
      wake_req <= cond && !cond_q;
    end
  end

  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req); // R11
  AST_WAKE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(stop_mode)); // R10
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q)); // R12
  AST_CFG_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == {$past(cfg_wdata[LEVEL_BIT]), $past(cfg_wdata[SRC_LSB+2:SRC_LSB])})); // R4
  AST_GRP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    grp_hit |-> grp_any); // R5
endmodule

// File: tb/stop_wake_sel_bench.sv
module stop_wake_sel_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic stop_mode = 0, cfg_we = 0, ref_we = 0, ref_sample = 0;
  logic [7:0] cfg_wdata = 0, ref_wdata = 0;
  logic [7:0] p0_in = 0, p2_in = 0, p3_in = 0;
  logic [7:0] p0_oe = 0, p2_oe = 0, p3_oe = 0;
  logic [7:0] p0_wsel = 0, p2_wsel = 0, p3_wsel = 0;
  logic wake_req;

  int n_chk = 0, n_fail = 0;
  int s_code = 0, s_lvl = 0;
  logic [3:0] s_en = 0, s_ref = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #4 clk = ~clk;

  stop_wake_sel u_stop_wake_sel (.*);

  function automatic logic [31:0] nxt(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic bit member(int code, int port, int b);
    bit p3g;
    p3g = (port == 3) && b >= 1 && b <= 3;
    case (code)
      1: return port == 2 && b < 4;
      2: return port == 2;
      3, 4: return p3g;
      5, 6: return p3g || (port == 0 && (b == 0 || b == 7));
      7: return p3g || (port == 2 && b <= 2);
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_group();
    bit any, allhi, anyhi, r, v, x;
    any = 0; allhi = 1; anyhi = 0;
    for (int port = 0; port < 4; port++) begin
      for (int b = 0; b < 8; b++) begin
        if (port == 1) continue;
        v = port == 0 ? p0_in[b] : port == 2 ? p2_in[b] : p3_in[b];
        x = port == 0 ? (p0_oe[b] | p0_wsel[b]) : port == 2 ? (p2_oe[b] | p2_wsel[b])
                                                            : (p3_oe[b] | p3_wsel[b]);
        if (member(s_code, port, b) && !x) begin
          any = 1; allhi &= v; anyhi |= v;
        end
      end
    end
    r = (s_code == 3 || s_code == 5) ? !anyhi : !allhi;
    return s_code != 0 && any && (r == s_lvl[0]);
  endfunction

  function automatic bit exp_ref();
    return |(s_en & (p3_in[3:0] ^ s_ref));
  endfunction

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wake_req=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int code, input int lvl, input logic [7:0] junk);
    @(negedge clk);
    cfg_we = 1;
    cfg_wdata = {junk[7], lvl[0], junk[5], code[2:0], junk[1:0]};
    s_code = code; s_lvl = lvl;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic write_ref(input logic [3:0] en, input logic [3:0] rv);
    @(negedge clk);
    ref_we = 1; ref_wdata = {rv, en};
    s_en = en; s_ref = rv;
    @(negedge clk);
    ref_we = 0;
  endtask

  // pins already set; stop low for settling, then raise and check
  task automatic run_case(input logic exp, input string req);
    @(negedge clk);
    stop_mode = 0;
    repeat (4) @(negedge clk);
    stop_mode = 1;
    @(negedge clk);
    chk(wake_req, exp, req);
    @(negedge clk);
    chk(wake_req, 1'b0, "R11");
    stop_mode = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: wake_req=%b expected=done", wake_req);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, nothing selected
    chk(wake_req, 1'b0, "R1");
    run_case(1'b0, "R1");

    // R2 R3 R4 R5: sweep every code and level
    for (int code = 0; code < 8; code++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        rng = nxt(rng);
        write_cfg(code, lvl, rng[7:0]);
        for (int k = 0; k < 24; k++) begin
          rng = nxt(rng); p0_in = rng[7:0]; p2_in = rng[15:8]; p3_in = rng[23:16];
          rng = nxt(rng);
          if (k == 0) begin p0_in = 0; p2_in = 0; p3_in = 0; end
          if (k == 1) begin p0_in = '1; p2_in = '1; p3_in = '1; end
          if (k < 8) begin
            p0_oe = 0; p2_oe = 0; p3_oe = 0; p0_wsel = 0; p2_wsel = 0; p3_wsel = 0;
          end else begin
            p0_oe = rng[7:0] & rng[15:8]; p2_oe = rng[15:8] & rng[23:16];
            p3_oe = rng[23:16] & rng[31:24]; p0_wsel = rng[31:24] & rng[7:0];
            p2_wsel = rng[7:0] & rng[23:16]; p3_wsel = rng[15:8] & rng[31:24];
          end
          if (k == 2 || k == 3) begin
            p0_oe = '1; p2_wsel = '1; p3_oe = {4'h0, k == 2 ? 4'hF : 4'h0};
            p3_wsel = {4'h0, k == 3 ? 4'hF : 4'h0};
          end
          run_case(exp_group(), "R2 R3 R4 R5");
        end
      end
    end
    p0_oe = 0; p2_oe = 0; p3_oe = 0; p0_wsel = 0; p2_wsel = 0; p3_wsel = 0;

    // R6: reference compare over all nibbles
    write_cfg(0, 0, 8'h00);
    for (int rv = 0; rv < 16; rv++) begin
      write_ref(4'hF, rv[3:0]);
      for (int pv = 0; pv < 16; pv++) begin
        p3_in = {4'h0, pv[3:0]};
        run_case(exp_ref(), "R6");
      end
    end
    write_ref(4'b0100, 4'h0);
    p3_in = 8'h0B; run_case(1'b0, "R6");
    p3_in = 8'h04; run_case(1'b1, "R6");

    // R7: sample capture
    write_ref(4'hF, 4'h0);
    p3_in = 8'h0A;
    repeat (3) @(negedge clk);
    ref_sample = 1; @(negedge clk); ref_sample = 0;
    s_ref = 4'hA;
    run_case(1'b0, "R7");
    p3_in = 8'h0B; run_case(1'b1, "R7");

    // R9: either source alone
    write_ref(4'hF, 4'h5);
    write_cfg(1, 0, 8'hFF);
    p2_in = 8'h0F; p3_in = 8'h05; run_case(1'b1, "R9");
    p2_in = 8'h00; p3_in = 8'h06; run_case(1'b1, "R9");
    p2_in = 8'h00; p3_in = 8'h05; run_case(1'b0, "R9");

    // R8: reference kept across wake
    p2_in = 8'h0F; run_case(1'b1, "R8");
    write_cfg(0, 0, 8'h00);
    p3_in = 8'h05; run_case(1'b0, "R8");
    p3_in = 8'h04; run_case(1'b1, "R8");
    write_ref(4'h0, 4'h0);

    // R10: run mode never wakes
    write_cfg(1, 1, 8'h00);
    stop_mode = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); p2_in = {4'h0, i[0] ? 4'h0 : 4'hF};
      chk(wake_req, 1'b0, "R10");
    end

    // R11: pin-to-pulse latency of three edges
    p2_in = 8'hFF;
    repeat (4) @(negedge clk);
    stop_mode = 1;
    repeat (4) @(negedge clk);
    chk(wake_req, 1'b0, "R11");
    p2_in = 8'hFE;
    @(negedge clk); chk(wake_req, 1'b0, "R11");
    @(negedge clk); chk(wake_req, 1'b0, "R11");
    @(negedge clk); chk(wake_req, 1'b1, "R11");
    @(negedge clk); chk(wake_req, 1'b0, "R11");

    // R12: config changes only on write
    stop_mode = 0; p2_in = 8'hFE;
    @(negedge clk); cfg_wdata = 8'h00;
    run_case(1'b1, "R12");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule